// File: doc/BRIEF.md
# Floppy Drive Media Status and Write Qualification

This block sits on the drive side of a floppy interface. It watches three cartridge sensors (disk present, write-inhibit hole open, high-density hole) and the host's active-low control lines (select, step, write gate, write data). From these it produces the host-facing media status: a sticky disk-change flag, a write-protect level and a density level. It also produces two signals for the recording path: a write-mode enable and a one-cycle flux-transition pulse taken from the write-data line.

The disk-change flag is set by power-on reset and while no disk is installed. It is cleared only when a disk is in place and the host issues a step while the drive is selected, so a plain status poll never clears it. Every input first passes through a two-flop synchronizer. Every result is registered once after that, which gives a fixed latency of three clocks from any input change to the output. The tri-state drivers outside the block are modelled by an output-enable that follows drive select.

Top module: `fdd_media_ctl`

## Requirements
- R1: While `rst_n` is low, `dchg_n`=0, `wprot_n`=0, `hd_out`=1, `wmode`=0, `wdata_pulse`=0 and `oe`=0.
- R2: While `disk_in`=0, `dchg_n` is 0 three clocks after that input value, and it stays 0 until a clearing step.
- R3: `dchg_n` returns to 1 three clocks after a falling edge of `step_n` that occurs while `disk_in`=1 and `sel_n`=0. A step without select, or a step with no disk, leaves the flag set.
- R4: `wmode` is 1 exactly when, three clocks earlier, `sel_n`=0, `wgate_n`=0 and the disk was not protected.
- R5: A disk counts as protected when `wp_open`=1 or `disk_in`=0. `wprot_n` is 0 (true) three clocks after such an input state and 1 otherwise.
- R6: `wdata_pulse` is high for one clock, three clocks after a falling edge of `wdata_n`, only if the R4 write conditions held at that edge. All other `wdata_n` edges produce no pulse.
- R7: `hd_out` is 1 when `hd_hole`=1 or `disk_in`=0, and 0 for a normal-density disk, three clocks after the inputs.
- R8: `oe` is 1 three clocks after `sel_n`=0 and 0 three clocks after `sel_n`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| disk_in | input | 1 | Cartridge present switch, 1 = installed |
| wp_open | input | 1 | Write-inhibit hole switch, 1 = hole open |
| hd_hole | input | 1 | Density hole switch, 1 = high-density cartridge |
| sel_n | input | 1 | Drive select from host, active low |
| step_n | input | 1 | Head step strobe, active low |
| wgate_n | input | 1 | Write gate, active low |
| wdata_n | input | 1 | Write data pulses, active low, leading edge significant |
| dchg_n | output | 1 | Disk-change flag, active low |
| wprot_n | output | 1 | Write-protect status, active low |
| hd_out | output | 1 | Density report, high for HD or empty drive |
| wmode | output | 1 | Write-mode enable for the recording path |
| wdata_pulse | output | 1 | One-clock flux-transition strobe |
| oe | output | 1 | Output enable for the external tri-state drivers |

## Verification
Level outputs (`oe`, `wprot_n`, `hd_out`, `wmode`) are due three clocks after the input value that produces them. The edge results (`wdata_pulse` and the clearing of `dchg_n`) depend on the input values three and four clocks back. The bench drives inputs on the falling clock edge and keeps a four-deep history of what it drove. On every falling edge it compares each output with the value computed from the history entries three and four back, so every check samples half a cycle after the register that is due.

// File: rtl/fdd_media_ctl.sv
`timescale 1ns/1ps
module fdd_media_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic disk_in,
  input  logic wp_open,
  input  logic hd_hole,
  input  logic sel_n,
  input  logic step_n,
  input  logic wgate_n,
  input  logic wdata_n,
  output logic dchg_n,
  output logic wprot_n,
  output logic hd_out,
  output logic wmode,
  output logic wdata_pulse,
  output logic oe
);
  localparam int NIN = 7;
  localparam logic [NIN-1:0] IDLE = 7'b1111000;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] sync_q [SYNC_STAGES];
  logic [NIN-1:0] s;
  logic step_prev, wd_prev;
  logic dchg_q, prot_q, hd_q, wmode_q, pulse_q, oe_q;

  assign raw = {sel_n, step_n, wgate_n, wdata_n, disk_in, wp_open, hd_hole};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s = sync_q[SYNC_STAGES-1];

  logic s_sel_n, s_step_n, s_wgate_n, s_wdata_n, s_disk, s_wp, s_hd;
  assign {s_sel_n, s_step_n, s_wgate_n, s_wdata_n, s_disk, s_wp, s_hd} = s;

  logic prot, wr_ok, step_fall, wd_fall;
  assign prot      = s_wp | ~s_disk;
  assign wr_ok     = ~s_sel_n & ~s_wgate_n & ~prot;
  assign step_fall = step_prev & ~s_step_n;
  assign wd_fall   = wd_prev & ~s_wdata_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_prev <= 1'b1;
      wd_prev   <= 1'b1;
      dchg_q    <= 1'b1;
      prot_q    <= 1'b1;
      hd_q      <= 1'b1;
      wmode_q   <= 1'b0;
      pulse_q   <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      step_prev <= s_step_n;
      wd_prev   <= s_wdata_n;
      if (!s_disk)                       dchg_q <= 1'b1;
      else if (step_fall && !s_sel_n)    dchg_q <= 1'b0;
      prot_q    <= prot;
      hd_q      <= s_hd | ~s_disk;
      wmode_q   <= wr_ok;
      pulse_q   <= wd_fall & wr_ok;
      oe_q      <= ~s_sel_n;
    end
  end

  assign dchg_n      = ~dchg_q;
  assign wprot_n     = ~prot_q;
  assign hd_out      = hd_q;
  assign wmode       = wmode_q;
  assign wdata_pulse = pulse_q;
  assign oe          = oe_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R6
  AST_PULSE_IN_WMODE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> wmode_q); // R6
  AST_WMODE_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    wmode_q |-> (!prot_q && oe_q)); // R4
  AST_DCHG_CLEAR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dchg_q) |-> oe_q); // R3
  AST_DCHG_SET_NODISK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dchg_q) |-> (hd_q && prot_q)); // R2
endmodule

// File: tb/fdd_media_ctl_bench.sv
`timescale 1ns/1ps
module fdd_media_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disk_in, wp_open, hd_hole, sel_n, step_n, wgate_n, wdata_n;
  logic dchg_n, wprot_n, hd_out, wmode, wdata_pulse, oe;

  int checks = 0;
  int fails  = 0;

  localparam logic [6:0] IDLE = 7'b1111000;
  logic [6:0] hist [1:4];
  logic exp_dchg;

  always #2.5 clk = ~clk;

  fdd_media_ctl u_fdd_media_ctl (
    .clk(clk), .rst_n(rst_n), .disk_in(disk_in), .wp_open(wp_open),
    .hd_hole(hd_hole), .sel_n(sel_n), .step_n(step_n), .wgate_n(wgate_n),
    .wdata_n(wdata_n), .dchg_n(dchg_n), .wprot_n(wprot_n), .hd_out(hd_out),
    .wmode(wmode), .wdata_pulse(wdata_pulse), .oe(oe)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic f_prot(input logic [6:0] v);
    return v[1] | ~v[2];
  endfunction
  function automatic logic f_wr(input logic [6:0] v);
    return ~v[6] & ~v[4] & ~f_prot(v);
  endfunction

  task automatic apply(input logic [6:0] v);
    {sel_n, step_n, wgate_n, wdata_n, disk_in, wp_open, hd_hole} = v;
  endtask

  task automatic tick(input logic [6:0] v);
    @(negedge clk);
    if (!hist[3][2]) exp_dchg = 1'b1;
    else if (hist[4][5] && !hist[3][5] && !hist[3][6]) exp_dchg = 1'b0;
    chk("R2/R3 dchg_n", dchg_n, ~exp_dchg);
    chk("R5 wprot_n", wprot_n, ~f_prot(hist[3]));
    chk("R7 hd_out", hd_out, hist[3][0] | ~hist[3][2]);
    chk("R4 wmode", wmode, f_wr(hist[3]));
    chk("R6 wdata_pulse", wdata_pulse, hist[4][3] & ~hist[3][3] & f_wr(hist[3]));
    chk("R8 oe", oe, ~hist[3][6]);
    apply(v);
    hist[4] = hist[3]; hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = v;
  endtask

  task automatic hold(input logic [6:0] v, input int n);
    for (int i = 0; i < n; i++) tick(v);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    apply(IDLE);
    for (int i = 1; i <= 4; i++) hist[i] = IDLE;
    exp_dchg = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 dchg_n", dchg_n, 1'b0);
    chk("R1 wprot_n", wprot_n, 1'b0);
    chk("R1 hd_out", hd_out, 1'b1);
    chk("R1 wmode", wmode, 1'b0);
    chk("R1 wdata_pulse", wdata_pulse, 1'b0);
    chk("R1 oe", oe, 1'b0);
    rst_n = 1'b1;
    // R3 corner: step with disk but no select keeps flag
    hold(7'b1111100, 5);
    hold(7'b1011100, 5);
    hold(7'b1111100, 5);
    // R3 corner: step selected with no disk keeps flag
    hold(7'b0111000, 5);
    hold(7'b0011000, 5);
    // R3: selected step with disk clears
    hold(7'b0111101, 5);
    hold(7'b0011101, 5);
    hold(7'b0111101, 5);
    // R6/R4: write pulses with gate on, then protected, then gate off
    hold(7'b0101101, 4); hold(7'b0100101, 2); hold(7'b0101101, 4);
    hold(7'b0101111, 4); hold(7'b0100111, 2); hold(7'b0101111, 4);
    hold(7'b0111101, 4); hold(7'b0110101, 2); hold(7'b0111101, 4);
    // R2: removal sets flag, reinsertion keeps it
    hold(7'b0111000, 5);
    hold(7'b0111100, 5);
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] v;
      v[6] = ($urandom % 4) == 0;
      v[5] = $urandom % 2;
      v[4] = ($urandom % 3) == 0;
      v[3] = $urandom % 2;
      v[2] = ($urandom % 8) != 0;
      v[1] = ($urandom % 4) == 0;
      v[0] = $urandom % 2;
      tick(v);
    end
    hold(IDLE, 6);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule